// File: doc/BRIEF.md
# Transfer Interface Interrupt Controller

This block holds the interrupt registers of a host-facing command transfer interface. Four single-cycle event pulses come in from the neighbouring logic: data available, status valid, locality change and command ready. Each pulse is latched into a sticky status word. The host reads that word to find the cause and clears it by writing ones to the bits it has handled. A configuration word selects which sources may interrupt and carries a global enable in its top bit. The same word holds a two-bit field that chooses how the single interrupt pin signals. The pin can be an active-high level or an active-low level. It can also be a rising or falling one-cycle pulse that marks each newly pending cause.

The block also has an 8-bit vector register that software may assign, where zero means unassigned. A constant capability word tells software which signalling modes exist, that command-ready interrupts are supported and whether the burst count is static. All registers are accessed through one 32-bit register port with byte offsets. Reads are combinational and writes take effect at the clock edge.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset the enable, vector and status registers read 0. The pin is low, because reset selects the active-high level mode.
- R2: A pulse on a source input sets its status bit at the next clock edge, and the bit stays set until cleared. The source positions are: data available bit 0, status valid bit 1, locality change bit 2, command ready bit 7.
- R3: A write to the status register at offset 0x10 clears each bit that is 1 in the written data and leaves the other bits unchanged.
- R4: If a source pulse and a clearing write for the same bit arrive in the same cycle, the bit stays set.
- R5: While enable bit 31 (global enable) is 0, the pin rests at its inactive level whatever the status and per-source enable bits are.
- R6: In mode 00 (enable bits 4:3), the pin is high exactly when the global enable is 1 and the status AND the per-source enables is non-zero. The per-source enables sit at bit positions 0, 1, 2 and 7 of the enable register.
- R7: Mode 01 is active-low: the pin is low exactly when an enabled cause is pending, and high otherwise.
- R8: Mode 11 is rising edge. The pin rests low and goes high for one cycle in the cycle after a source becomes newly pending. A repeat pulse on an already pending source gives no new pulse. Enabling a source whose status is already set counts as newly pending.
- R9: Mode 10 is falling edge. The pin rests high and goes low for one cycle on the same condition as R8.
- R10: The vector register at offset 0x0C stores the low 8 bits written, and its upper bits read 0.
- R11: The capability register at offset 0x14 reads a constant that ignores writes. It has 1 at bits 0 to 7 (bits 0 to 2 and 7 for source interrupts, bits 3 to 6 for level high, level low, rising and falling, bit 7 also for command ready). Bit 8 equals the STATIC_BURST parameter, which defaults to 1, so the constant is 0x1FF.
- R12: The enable register at offset 0x08 keeps only bits 31, 7, 4, 3, 2, 1 and 0. Writing all ones reads back 0x8000009F. Status bits other than 0, 1, 2 and 7 always read 0.
- R13: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ev_data_avail | input | 1 | Data available event pulse |
| ev_sts_valid | input | 1 | Status valid event pulse |
| ev_loc_chg | input | 1 | Locality change event pulse |
| ev_cmd_rdy | input | 1 | Command ready event pulse |
| irq_out | output | 1 | Interrupt pin, behaviour set by the mode field |

## Verification
The bench sends a source pulse in the same cycle as a clearing write for that bit. A design that lets the clear win would lose the event and the status would read 0x80 instead of 0x82. In the edge modes it repeats a pulse on a source that is already pending, and it switches the enable mask while causes are pending. A design that fires on the level rather than on a newly pending cause would pulse again or hold the pin. The bench drops the global enable while a cause is set with the active-low mode selected. A design that gates the wrong way would drive the pin low. It also writes all ones to the enable register and writes to the capability register. A design that kept unimplemented bits, or let the capability word be written, reads back the wrong value.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int REG_W    = 32;
    localparam int SRC_N    = 4;
    localparam int GIE_BIT  = 31;
    localparam int MODE_LSB = 3;

    typedef enum logic [1:0] {
        OUT_LVL_HI    = 2'b00,
        OUT_LVL_LO    = 2'b01,
        OUT_EDGE_FALL = 2'b10,
        OUT_EDGE_RISE = 2'b11
    } out_mode_e;

    localparam logic [7:0] OFS_EN  = 8'h08;
    localparam logic [7:0] OFS_VEC = 8'h0C;
    localparam logic [7:0] OFS_STS = 8'h10;
    localparam logic [7:0] OFS_CAP = 8'h14;

    // status / enable bit position of each event source (software decodes these)
    function automatic int src_pos(input int idx);
        case (idx)
            0:       return 0;   // data available
            1:       return 1;   // status valid
            2:       return 2;   // locality change
            default: return 7;   // command ready
        endcase
    endfunction

    function automatic logic [REG_W-1:0] src_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < SRC_N; i++) m[src_pos(i)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/xirq_status.sv
module xirq_status #(
    parameter int            W    = 32,
    parameter logic [W-1:0]  IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);

    typedef struct packed {
        logic [W-1:0] stat;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        // set wins over a same-cycle clear
        s_d.stat = ((s_q.stat & ~clr_i) | set_i) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_o = s_q.stat;

    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & IMPL) != '0) |=>
        ((stat_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i & IMPL) != '0) |=>
        ((stat_o & $past(clr_i & ~set_i & IMPL)) == '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(stat_o));

    p_race_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & clr_i & IMPL) != '0) |=>
        ((stat_o & $past(set_i & clr_i & IMPL)) == $past(set_i & clr_i & IMPL)));

endmodule

// File: rtl/xirq_outgen.sv
module xirq_outgen
    import xirq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend_i,
    input  out_mode_e    mode_i,
    output logic         irq_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } og_t;

    og_t o_d, o_q;
    logic fresh;
    logic active;

    always_comb begin
        o_d      = o_q;
        o_d.prev = pend_i;
        fresh    = |(pend_i & ~o_q.prev);
        active   = |pend_i;
        case (mode_i)
            OUT_LVL_HI:    irq_o = active;
            OUT_LVL_LO:    irq_o = ~active;
            OUT_EDGE_RISE: irq_o = fresh;
            default:       irq_o = ~fresh;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0 && mode_i == OUT_LVL_HI) |-> !irq_o);

    p_rise_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OUT_EDGE_RISE && $stable(pend_i)) |-> !irq_o);

    p_fall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OUT_EDGE_FALL && $stable(pend_i)) |-> irq_o);

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int       ADDR_W       = 8,
    parameter int       VEC_W        = 8,
    parameter logic     STATIC_BURST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_data_avail,
    input  logic              ev_sts_valid,
    input  logic              ev_loc_chg,
    input  logic              ev_cmd_rdy,
    output logic              irq_out
);

    localparam logic [REG_W-1:0]  SRC_MASK = src_mask();
    localparam logic [REG_W-1:0]  EN_IMPL  = SRC_MASK
                                           | (REG_W'(1) << GIE_BIT)
                                           | (REG_W'(3) << MODE_LSB);
    localparam logic [REG_W-1:0]  CAP_VAL  = SRC_MASK | REG_W'(32'h78)
                                           | (REG_W'(STATIC_BURST) << 8);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(OFS_VEC);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(OFS_CAP);

    typedef struct packed {
        logic [REG_W-1:0] en;
        logic [VEC_W-1:0] vec;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [SRC_N-1:0] ev_bus;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] stat;
    logic [REG_W-1:0] pend;
    logic             gie;
    out_mode_e        mode;

    assign ev_bus = {ev_cmd_rdy, ev_loc_chg, ev_sts_valid, ev_data_avail};

    // route each source pulse to its status position
    for (genvar g = 0; g < REG_W; g++) begin : g_route
        always_comb begin
            set_vec[g] = 1'b0;
            for (int s = 0; s < SRC_N; s++)
                if (src_pos(s) == g) set_vec[g] = ev_bus[s];
        end
    end

    always_comb begin
        cfg_d   = cfg_q;
        clr_vec = '0;
        if (reg_wr) begin
            if (reg_addr == A_EN)  cfg_d.en  = reg_wdata & EN_IMPL;
            if (reg_addr == A_VEC) cfg_d.vec = reg_wdata[VEC_W-1:0];
            if (reg_addr == A_STS) clr_vec   = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    xirq_status #(
        .W    (REG_W),
        .IMPL (SRC_MASK)
    ) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .stat_o (stat)
    );

    assign gie  = cfg_q.en[GIE_BIT];
    assign mode = out_mode_e'(cfg_q.en[MODE_LSB +: 2]);
    assign pend = stat & cfg_q.en & SRC_MASK & {REG_W{gie}};

    xirq_outgen #(
        .W (REG_W)
    ) u_outgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .mode_i (mode),
        .irq_o  (irq_out)
    );

    always_comb begin
        case (reg_addr)
            A_EN:    reg_rdata = cfg_q.en;
            A_VEC:   reg_rdata = 32'(cfg_q.vec);
            A_STS:   reg_rdata = stat;
            A_CAP:   reg_rdata = CAP_VAL;
            default: reg_rdata = '0;
        endcase
    end

    p_gie_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (irq_out == (mode == OUT_LVL_LO || mode == OUT_EDGE_FALL)));

    p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_VEC) |=> $stable(cfg_q.vec));

endmodule

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [3:0]  ev;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    xirq_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ev_data_avail (ev[0]),
        .ev_sts_valid  (ev[1]),
        .ev_loc_chg    (ev[2]),
        .ev_cmd_rdy    (ev[3]),
        .irq_out       (irq_out)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [3:0]  ev;
        logic [7:0]  raddr;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 8'h00, 32'h0,          4'b0001, 8'h10, 32'h00000001, 1'b0, 8'd2},  // R2
        '{1'b0, 8'h00, 32'h0,          4'b1000, 8'h10, 32'h00000081, 1'b0, 8'd2},  // R2
        '{1'b1, 8'h08, 32'h00000001,   4'b0000, 8'h08, 32'h00000001, 1'b0, 8'd5},  // R5
        '{1'b1, 8'h08, 32'h80000001,   4'b0000, 8'h08, 32'h80000001, 1'b1, 8'd6},  // R6
        '{1'b1, 8'h10, 32'h00000001,   4'b0000, 8'h10, 32'h00000080, 1'b0, 8'd3},  // R3
        '{1'b1, 8'h08, 32'hFFFFFFFF,   4'b0000, 8'h08, 32'h8000009F, 1'b1, 8'd12}, // R12, R8
        '{1'b0, 8'h00, 32'h0,          4'b0000, 8'h10, 32'h00000080, 1'b0, 8'd8},  // R8
        '{1'b0, 8'h00, 32'h0,          4'b0010, 8'h10, 32'h00000082, 1'b1, 8'd8},  // R8
        '{1'b0, 8'h00, 32'h0,          4'b0010, 8'h10, 32'h00000082, 1'b0, 8'd8},  // R8
        '{1'b1, 8'h10, 32'h00000002,   4'b0010, 8'h10, 32'h00000082, 1'b0, 8'd4},  // R4
        '{1'b1, 8'h08, 32'h80000017,   4'b0000, 8'h08, 32'h80000017, 1'b1, 8'd9},  // R9
        '{1'b0, 8'h00, 32'h0,          4'b0100, 8'h10, 32'h00000086, 1'b0, 8'd9},  // R9
        '{1'b0, 8'h00, 32'h0,          4'b0000, 8'h10, 32'h00000086, 1'b1, 8'd9},  // R9
        '{1'b1, 8'h08, 32'h8000000F,   4'b0000, 8'h08, 32'h8000000F, 1'b0, 8'd7},  // R7
        '{1'b1, 8'h10, 32'hFFFFFFFF,   4'b0000, 8'h10, 32'h00000000, 1'b1, 8'd7},  // R7, R3
        '{1'b1, 8'h0C, 32'h123456A5,   4'b0000, 8'h0C, 32'h000000A5, 1'b1, 8'd10}, // R10
        '{1'b1, 8'h14, 32'h00000000,   4'b0000, 8'h14, 32'h000001FF, 1'b1, 8'd11}, // R11
        '{1'b0, 8'h00, 32'h0,          4'b0000, 8'h04, 32'h00000000, 1'b1, 8'd13}, // R13
        '{1'b1, 8'h08, 32'h00000008,   4'b0001, 8'h10, 32'h00000001, 1'b1, 8'd5}   // R5
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // drive one cycle of stimulus at a falling edge, release at the next
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] e);
        @(negedge clk);
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = d;
        ev        = e;
        @(negedge clk);
        reg_wr    = 1'b0;
        ev        = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; ev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h08, v); chk("R1 enable", v, 32'h0);
        rd(8'h0C, v); chk("R1 vector", v, 32'h0);
        rd(8'h10, v); chk("R1 status", v, 32'h0);
        chk("R1 irq", 32'(irq_out), 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].wr, TBL[i].waddr, TBL[i].wdata, TBL[i].ev);
            rd(TBL[i].raddr, v);
            chk($sformatf("R%0d entry %0d read", TBL[i].req, i), v, TBL[i].exp_rd);
            chk($sformatf("R%0d entry %0d irq", TBL[i].req, i), 32'(irq_out), 32'(TBL[i].exp_irq));
        end

        // R11 capability ignores a non-zero write too
        step(1'b1, 8'h14, 32'hFFFFFFFF, 4'b0000);
        rd(8'h14, v); chk("R11 cap after write", v, 32'h000001FF);

        // R4 race on command-ready bit in rising mode
        step(1'b1, 8'h08, 32'h80000098, 4'b0000);
        step(1'b1, 8'h10, 32'h00000080, 4'b1000);
        rd(8'h10, v); chk("R4 race bit7", v, 32'h00000081);

        // R1 mid-run reset returns everything to zero
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'h08, v); chk("R1 enable after reset", v, 32'h0);
        rd(8'h10, v); chk("R1 status after reset", v, 32'h0);
        rd(8'h0C, v); chk("R1 vector after reset", v, 32'h0);
        chk("R1 irq after reset", 32'(irq_out), 32'h0);

        finish_run();
    end

endmodule